// File: doc/BRIEF.md
# NAND Sequential Cache Page Reader

This block reads a run of physically consecutive pages from a raw NAND flash device on an 8-bit bus. A one-cycle start request gives a starting row address, a page count and a mode bit. In cached mode the reader opens the first page once. It then chains cache-continue and cache-end commands, so the device loads the next page into its array register while the host shifts out the current page from the cache. In plain mode, and whenever the run is a single page, every page gets its own open-address-read sequence.

The reader drives the command-latch, address-latch, write-enable and read-enable strobes. It watches the ready/busy pin through a two-flop synchronizer and counts all bus timing in clock cycles. Every byte it reads leaves on a valid/ready stream, and a low ready on that stream holds off the next read strobe. A single-cycle done pulse marks the point where the final byte has been handed downstream.

Top module: `nand_seq_reader`

## Requirements
- R1: A run opens its first page with a CLE write of 0x00, then five ALE writes (two zero column bytes, then the three row-address bytes with the least significant byte first), then a CLE write of 0x30.
- R2: In cached mode with a count N of at least 2, the command bytes are exactly 0x00, 0x30, then 0x31 repeated N-1 times, then 0x3F. No address cycles follow the first open. The bytes of row A+k arrive after the (k+1)-th cache command.
- R3: No read strobe falls while the ready/busy pin is low, and the first read strobe of a page comes at least TRR_CYC cycles after the device returns ready.
- R4: Each page produces exactly PAGE_BYTES read strobes (2048 by default), and the stream carries the bytes of rows A, A+1, ... in bus order.
- R5: When the mode bit is 0 or the count is 1, each page k is read with 0x00, five address cycles carrying row A+k, and 0x30, and no 0x31 or 0x3F is issued.
- R6: CLE and ALE are never high together, and write-enable and read-enable are never low together.
- R7: Every read-enable low pulse lasts exactly RE_LO_CYC cycles.
- R8: While the output is valid and not accepted, the valid flag and the data byte stay unchanged, and no captured byte overwrites one that has not been accepted.
- R9: done_o is high for exactly one cycle: the cycle after the final byte of the last page is accepted.
- R10: A start request that arrives while busy_o is high has no effect on the run in progress.
- R11: A start with a page count of 0 raises done_o in the next cycle. It produces no strobe and does not raise busy_o.
- R12: After reset, both latch enables are low, both strobes are high, and dout_valid_o, done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken only when idle |
| page_addr_i | input | ROW_W | Row address of the first page |
| page_cnt_i | input | CNT_W | Number of pages to read |
| seq_en_i | input | 1 | 1 selects the cached chain, 0 the plain per-page sequence |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_re_n_o | output | 1 | Read enable, active low |
| nand_io_o | output | 8 | Command or address byte to the flash |
| nand_io_oe_o | output | 1 | Bus drive enable for nand_io_o |
| nand_io_i | input | 8 | Data byte from the flash |
| nand_rb_i | input | 1 | Ready/busy pin, high when ready (asynchronous) |
| dout_data_o | output | 8 | Output data byte |
| dout_valid_o | output | 1 | Output byte valid |
| dout_ready_i | input | 1 | Downstream ready |
| done_o | output | 1 | One-cycle pulse after the final byte is accepted |
| busy_o | output | 1 | Run in progress |

## Verification
A wrong command step shows on the bus within one write strobe: a 0x31 in place of 0x3F makes the device model keep loading, and a missed step reads the wrong row. In both cases the first byte of the next page differs within a few dozen cycles of the command. A byte counter that is off by one moves every later byte by one position. It also changes the strobe total for that page, and the error is visible at the next page boundary. A lost wait for ready or a short tRR count shows as a read strobe inside the busy window at the first data byte. A bad last-byte flag moves or removes done_o relative to the final handshake.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_BUSY, S_TRR, S_RD_WAIT, S_RD_LO, S_RD_HI, S_FIN
  } nseq_st_t;

  localparam logic [7:0] OP_OPEN  = 8'h00;
  localparam logic [7:0] OP_READ  = 8'h30;
  localparam logic [7:0] OP_CNEXT = 8'h31;
  localparam logic [7:0] OP_CLAST = 8'h3F;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // byte sent in address cycle idx: two zero column bytes, then row LSB first
  function automatic logic [7:0] addr_byte(input logic [31:0] row, input int unsigned idx);
    logic [31:0] sh;
    if (idx < 2) return 8'h00;
    sh = row >> (8 * (idx - 2));
    return sh[7:0];
  endfunction

  // command that requests the next page from cache
  function automatic logic [7:0] cache_op(input logic final_page);
    return final_page ? OP_CLAST : OP_CNEXT;
  endfunction

endpackage

// File: rtl/nseq_sync.sv
module nseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nseq_ostage.sv
module nseq_ostage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_last,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         last,
  output logic         slot_free,
  output logic         fire
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      last  <= load_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assign slot_free = !valid || ready;
  assign fire      = valid && ready;
endmodule

// File: rtl/nand_seq_reader.sv
module nand_seq_reader
  import nseq_pkg::*;
#(
  parameter int ROW_W       = 24,
  parameter int CNT_W       = 16,
  parameter int PAGE_BYTES  = 2048,
  parameter int WE_LO_CYC   = 2,
  parameter int WE_HI_CYC   = 2,
  parameter int RE_LO_CYC   = 2,
  parameter int RE_HI_CYC   = 1,
  parameter int TRR_CYC     = 4,
  parameter int TWB_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ROW_W-1:0] page_addr_i,
  input  logic [CNT_W-1:0] page_cnt_i,
  input  logic             seq_en_i,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  output logic             nand_re_n_o,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i,
  output logic [7:0]       dout_data_o,
  output logic             dout_valid_o,
  input  logic             dout_ready_i,
  output logic             done_o,
  output logic             busy_o
);
  localparam int ROW_BYTES = (ROW_W + 7) / 8;
  localparam int ADDR_CYC  = 2 + ROW_BYTES;
  localparam int AIDX_W    = $clog2(ADDR_CYC);
  localparam int BIDX_W    = $clog2(PAGE_BYTES);
  localparam int TMAX      = max2(max2(max2(WE_LO_CYC, WE_HI_CYC), max2(RE_LO_CYC, RE_HI_CYC)),
                                  max2(TRR_CYC, TWB_CYC));
  localparam int TMR_W     = $clog2(TMAX + 1);

  nseq_st_t          st;
  logic [TMR_W-1:0]  tmr;
  logic              ph;
  logic [7:0]        cur_op;
  logic [ROW_W-1:0]  row;
  logic [CNT_W-1:0]  rd_left;
  logic              seq_m;
  logic [AIDX_W-1:0] aidx;
  logic [BIDX_W-1:0] bidx;
  logic              done_r;

  // named internal events
  logic        rb_s, tmr_end, start_ok, strobe_end, byte_cap, page_end, cap_last;
  logic        slot_free, o_fire, o_last;
  logic        issue;
  logic [7:0]  issue_op;
  logic [31:0] row32;

  nseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_i), .q(rb_s)
  );

  assign tmr_end    = (tmr == '0);
  assign start_ok   = start_i && (st == S_IDLE);
  assign strobe_end = ((st == S_CMD) || (st == S_ADDR)) && tmr_end && ph;
  assign byte_cap   = (st == S_RD_LO) && tmr_end;
  assign page_end   = (st == S_RD_HI) && tmr_end && (bidx == BIDX_W'(PAGE_BYTES - 1));
  assign cap_last   = (bidx == BIDX_W'(PAGE_BYTES - 1)) && (rd_left == CNT_W'(1));
  assign row32      = 32'(row);

  nseq_ostage #(.W(8)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(byte_cap), .load_data(nand_io_i), .load_last(cap_last),
    .ready(dout_ready_i),
    .valid(dout_valid_o), .data(dout_data_o), .last(o_last),
    .slot_free(slot_free), .fire(o_fire)
  );

  // command issue decision
  always_comb begin
    issue    = 1'b0;
    issue_op = OP_OPEN;
    unique case (st)
      S_IDLE: if (start_ok && (page_cnt_i != '0)) begin
        issue = 1'b1; issue_op = OP_OPEN;
      end
      S_ADDR: if (strobe_end && (aidx == AIDX_W'(ADDR_CYC - 1))) begin
        issue = 1'b1; issue_op = OP_READ;
      end
      S_BUSY: if (tmr_end && rb_s && (cur_op == OP_READ) && seq_m) begin
        issue = 1'b1; issue_op = cache_op(rd_left == CNT_W'(1));
      end
      S_RD_HI: if (page_end && (rd_left != CNT_W'(1))) begin
        issue    = 1'b1;
        issue_op = seq_m ? cache_op(rd_left == CNT_W'(2)) : OP_OPEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      ph           <= 1'b0;
      cur_op       <= OP_OPEN;
      row          <= '0;
      rd_left      <= '0;
      seq_m        <= 1'b0;
      aidx         <= '0;
      bidx         <= '0;
      done_r       <= 1'b0;
      nand_cle_o   <= 1'b0;
      nand_ale_o   <= 1'b0;
      nand_we_n_o  <= 1'b1;
      nand_re_n_o  <= 1'b1;
      nand_io_o    <= 8'h00;
      nand_io_oe_o <= 1'b0;
    end else begin
      done_r <= (o_fire && o_last) || (start_ok && (page_cnt_i == '0));
      if (start_ok) begin
        row     <= page_addr_i;
        rd_left <= page_cnt_i;
        seq_m   <= seq_en_i && (page_cnt_i > CNT_W'(1));
      end
      if (page_end) begin
        rd_left <= rd_left - CNT_W'(1);
        if (!seq_m) row <= row + ROW_W'(1);
      end
      if (issue) begin
        st           <= S_CMD;
        cur_op       <= issue_op;
        nand_cle_o   <= 1'b1;
        nand_ale_o   <= 1'b0;
        nand_io_o    <= issue_op;
        nand_io_oe_o <= 1'b1;
        nand_we_n_o  <= 1'b0;
        ph           <= 1'b0;
        tmr          <= TMR_W'(WE_LO_CYC - 1);
      end else begin
        unique case (st)
          S_IDLE: ;
          S_CMD, S_ADDR: begin
            if (!tmr_end) tmr <= tmr - TMR_W'(1);
            else if (!ph) begin
              nand_we_n_o <= 1'b1;
              ph          <= 1'b1;
              tmr         <= TMR_W'(WE_HI_CYC - 1);
            end else if (st == S_CMD) begin
              nand_cle_o <= 1'b0;
              if (cur_op == OP_OPEN) begin
                st          <= S_ADDR;
                nand_ale_o  <= 1'b1;
                nand_io_o   <= addr_byte(row32, 0);
                nand_we_n_o <= 1'b0;
                ph          <= 1'b0;
                aidx        <= '0;
                tmr         <= TMR_W'(WE_LO_CYC - 1);
              end else begin
                st           <= S_BUSY;
                nand_io_oe_o <= 1'b0;
                tmr          <= TMR_W'(TWB_CYC - 1);
              end
            end else begin
              aidx        <= aidx + AIDX_W'(1);
              nand_io_o   <= addr_byte(row32, int'(aidx) + 1);
              nand_we_n_o <= 1'b0;
              ph          <= 1'b0;
              tmr         <= TMR_W'(WE_LO_CYC - 1);
            end
          end
          S_BUSY: begin
            if (!tmr_end) tmr <= tmr - TMR_W'(1);
            else if (rb_s) begin
              st  <= S_TRR;
              tmr <= TMR_W'(TRR_CYC - 1);
            end
          end
          S_TRR: begin
            if (!tmr_end) tmr <= tmr - TMR_W'(1);
            else begin
              st   <= S_RD_WAIT;
              bidx <= '0;
            end
          end
          S_RD_WAIT: if (slot_free) begin
            nand_re_n_o <= 1'b0;
            st          <= S_RD_LO;
            tmr         <= TMR_W'(RE_LO_CYC - 1);
          end
          S_RD_LO: begin
            if (!tmr_end) tmr <= tmr - TMR_W'(1);
            else begin
              nand_re_n_o <= 1'b1;
              st          <= S_RD_HI;
              tmr         <= TMR_W'(RE_HI_CYC - 1);
            end
          end
          S_RD_HI: begin
            if (!tmr_end) tmr <= tmr - TMR_W'(1);
            else if (page_end) st <= S_FIN;
            else begin
              bidx <= bidx + BIDX_W'(1);
              st   <= S_RD_WAIT;
            end
          end
          S_FIN: if (slot_free) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign done_o = done_r;
  assign busy_o = (st != S_IDLE);

endmodule

// File: rtl/nseq_chk.sv
module nseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic       re_n,
  input logic       rb_s,
  input logic       busy,
  input logic       start,
  input logic       cnt_zero,
  input logic       done,
  input logic       dv,
  input logic       dr,
  input logic [7:0] dd,
  input logic       byte_cap
);
  assert_latch_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  assert_read_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> rb_s);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dv && !dr) |=> (dv && $stable(dd)));

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cap |-> !dv);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_zero_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cnt_zero) |=> (done && !busy));

  assert_read_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> busy);
endmodule

bind nand_seq_reader nseq_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .cle(nand_cle_o), .ale(nand_ale_o), .we_n(nand_we_n_o), .re_n(nand_re_n_o),
  .rb_s(rb_s), .busy(busy_o), .start(start_i), .cnt_zero(page_cnt_i == '0),
  .done(done_o), .dv(dout_valid_o), .dr(dout_ready_i), .dd(dout_data_o),
  .byte_cap(byte_cap)
);

// File: tb/sim_nand_seq_reader.sv
`timescale 1ns/1ps
module sim_nand_seq_reader;
  localparam int PB = 2048, RE_LO = 1, RE_HI = 1, WE_LO = 1, WE_HI = 1, TRR = 3, TWB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, seq_en = 1'b0;
  logic [23:0] page_addr = '0;
  logic [15:0] page_cnt = '0;
  logic cle, ale, we_n, re_n, io_oe, dv, done, busy;
  logic [7:0] io_o, io_i, dd;
  logic rb = 1'b1, dr = 1'b0;

  always #2.5 clk = ~clk;

  nand_seq_reader #(.PAGE_BYTES(PB), .WE_LO_CYC(WE_LO), .WE_HI_CYC(WE_HI), .RE_LO_CYC(RE_LO),
    .RE_HI_CYC(RE_HI), .TRR_CYC(TRR), .TWB_CYC(TWB)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .page_addr_i(page_addr), .page_cnt_i(page_cnt),
    .seq_en_i(seq_en), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_n_o(we_n), .nand_re_n_o(re_n),
    .nand_io_o(io_o), .nand_io_oe_o(io_oe), .nand_io_i(io_i), .nand_rb_i(rb),
    .dout_data_o(dd), .dout_valid_o(dv), .dout_ready_i(dr), .done_o(done), .busy_o(busy));

  int total = 0, bad = 0;

  function automatic logic [7:0] dbyte(input int unsigned r, input int unsigned i);
    return 8'((r * 29) + i + (i >> 8) * 7);
  endfunction

  function automatic logic [7:0] exp_cmd(input int k, input int cnt, input bit sq);
    if (sq) begin
      if (k == 0) return 8'h00;
      if (k == 1) return 8'h30;
      if (k == cnt + 1) return 8'h3F;
      return 8'h31;
    end
    return (k % 2 == 0) ? 8'h00 : 8'h30;
  endfunction

  function automatic logic [7:0] exp_addr(input int j, input int unsigned base, input bit sq);
    int unsigned r;
    int pos;
    pos = j % 5;
    r = (base + (sq ? 0 : j / 5)) & 24'hFFFFFF;
    if (pos < 2) return 8'h00;
    return 8'(r >> (8 * (pos - 2)));
  endfunction

  // flash responder and port monitor, all on the falling edge
  int unsigned cur_row = 0, read_row = 0, idx = 0;
  logic [7:0] ad_cur [0:4];
  int ad_i = 0, busy_cnt = 0, rb_hi = 100;
  logic [7:0] cmd_log [0:15];
  logic [7:0] addr_log [0:31];
  int cmd_n = 0, addr_n = 0, re_falls = 0, we_falls = 0, re_len = 0;
  int bad_w = 0, bad_rb = 0, bad_trr = 0, bad_ex = 0, bad_st = 0;
  int rx_n = 0, rx_bad = 0, done_n = 0, done_ok = 0, busy_n = 0;
  logic exp_done = 1'b0, prev_we = 1'b1, prev_re = 1'b1, prev_st = 1'b0;
  logic [7:0] prev_d = '0;
  logic clr_log = 1'b0;
  int unsigned exp_base = 0;
  int exp_cnt = 0;

  assign io_i = dbyte(read_row, idx);

  always @(negedge clk) begin
    if (clr_log) begin
      cmd_n = 0; addr_n = 0; re_falls = 0; we_falls = 0; bad_w = 0; bad_rb = 0; bad_trr = 0;
      bad_ex = 0; bad_st = 0; rx_n = 0; rx_bad = 0; done_n = 0; done_ok = 0; busy_n = 0;
      exp_done = 1'b0; prev_st = 1'b0;
    end else if (rst_n) begin
      if (busy) busy_n++;
      if ((cle && ale) || (!we_n && !re_n)) bad_ex++;
      if (busy_cnt > 0) begin
        busy_cnt--;
        if (busy_cnt == 0) rb = 1'b1;
      end
      if (prev_we && !we_n) we_falls++;
      if (!prev_we && we_n) begin
        if (cle) begin
          if (cmd_n < 16) cmd_log[cmd_n] = io_o;
          cmd_n++;
          case (io_o)
            8'h00: ad_i = 0;
            8'h30: begin
              cur_row = {8'h00, ad_cur[4], ad_cur[3], ad_cur[2]};
              read_row = cur_row; idx = 0;
              busy_cnt = 3 + int'($urandom % 8); rb = 1'b0;
            end
            8'h31: begin
              read_row = cur_row; cur_row = (cur_row + 1) & 24'hFFFFFF; idx = 0;
              busy_cnt = 3 + int'($urandom % 8); rb = 1'b0;
            end
            8'h3F: begin
              read_row = cur_row; idx = 0;
              busy_cnt = 3 + int'($urandom % 8); rb = 1'b0;
            end
            default: ;
          endcase
        end
        if (ale) begin
          if (ad_i < 5) ad_cur[ad_i] = io_o;
          ad_i++;
          if (addr_n < 32) addr_log[addr_n] = io_o;
          addr_n++;
        end
      end
      if (!re_n) begin
        if (prev_re) begin
          re_falls++;
          if (!rb) bad_rb++;
          if (rb_hi < TRR) bad_trr++;
        end
        re_len++;
      end else if (!prev_re) begin
        if (re_len != RE_LO) bad_w++;
        re_len = 0;
        idx++;
      end
      if (rb) rb_hi++; else rb_hi = 0;
      if (prev_st && (!dv || dd != prev_d)) bad_st++;
      if (done) begin
        done_n++;
        if (exp_done) done_ok++;
      end
      exp_done = 1'b0;
      dr = ($urandom % 4) != 0;
      if (dv && dr) begin
        if (dd != dbyte((exp_base + rx_n / PB) & 24'hFFFFFF, rx_n % PB)) rx_bad++;
        rx_n++;
        if (rx_n == exp_cnt * PB) exp_done = 1'b1;
      end
      prev_st = dv && !dr;
      prev_d  = dd;
    end
    prev_we = we_n;
    prev_re = re_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int unsigned base, input int cnt, input bit sq, input bit inject);
    bit sqm;
    int cbad, abad, ncmd;
    sqm = sq && (cnt > 1);
    @(posedge clk); #1;
    clr_log = 1'b1; exp_base = base; exp_cnt = cnt;
    @(posedge clk); #1;
    clr_log = 1'b0;
    page_addr = base[23:0]; page_cnt = cnt[15:0]; seq_en = sq; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    if (inject) begin
      repeat (20) @(posedge clk);
      #1; start = 1'b1; page_addr = base[23:0] + 24'd100; page_cnt = 16'd1; seq_en = !sq;
      @(posedge clk); #1;
      start = 1'b0;
    end
    while (done_n == 0) @(posedge clk);
    repeat (8) @(posedge clk);
    ncmd = (cnt == 0) ? 0 : (sqm ? cnt + 2 : 2 * cnt);
    cbad = 0;
    for (int k = 0; k < cmd_n && k < 16; k++) if (cmd_log[k] != exp_cmd(k, cnt, sqm)) cbad++;
    abad = 0;
    for (int j = 0; j < addr_n && j < 32; j++) if (addr_log[j] != exp_addr(j, base, sqm)) abad++;
    if (cnt == 0) begin
      chk(we_falls == 0 && re_falls == 0, "R11 no strobes", we_falls + re_falls, 0);
      chk(busy_n == 0, "R11 busy stays low", busy_n, 0);
      chk(done_n == 1, "R11 done pulse", done_n, 1);
    end else begin
      if (sqm) chk(cmd_n == ncmd && cbad == 0, "R2 cached command chain", cmd_n * 100 + cbad, ncmd * 100);
      else     chk(cmd_n == ncmd && cbad == 0, "R5 plain command sequence", cmd_n * 100 + cbad, ncmd * 100);
      chk(addr_n == (sqm ? 5 : 5 * cnt) && abad == 0, "R1 address cycles",
          addr_n * 100 + abad, (sqm ? 5 : 5 * cnt) * 100);
      chk(re_falls == cnt * PB, "R4 read strobe count", re_falls, cnt * PB);
      chk(rx_n == cnt * PB && rx_bad == 0, "R4 stream bytes and order", rx_n * 10 + rx_bad, cnt * PB * 10);
      chk(bad_rb == 0 && bad_trr == 0, "R3 ready and tRR wait", bad_rb * 1000 + bad_trr, 0);
      chk(bad_ex == 0, "R6 strobe exclusion", bad_ex, 0);
      chk(bad_w == 0, "R7 read low width", bad_w, 0);
      chk(bad_st == 0, "R8 stall hold", bad_st, 0);
      chk(done_n == 1 && done_ok == 1, "R9 done timing", done_n * 10 + done_ok, 11);
      if (inject) chk(cmd_n == ncmd && rx_n == cnt * PB, "R10 start while busy ignored", rx_n, cnt * PB);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1;
    chk(!cle && !ale && we_n && re_n && !dv && !done && !busy, "R12 reset state",
        {cle, ale, we_n, re_n, dv, done, busy}, 7'b0011000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    run(24'h012345, 0, 1'b1, 1'b0);
    run(24'h0A0B0C, 1, 1'b1, 1'b0);
    run(24'h00FFFE, 3, 1'b1, 1'b0);
    run(24'h123400, 2, 1'b0, 1'b0);
    run(24'h045678, 2, 1'b1, 1'b1);
    for (int n = 0; n < 2; n++) begin
      int unsigned b;
      int c;
      bit s;
      b = $urandom & 32'h7FFFFF;
      c = 1 + int'($urandom % 3);
      s = $urandom % 2;
      run(b, c, s, 1'b0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule